// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM with Address Hold

This block is a synchronous simple dual-port RAM whose write port and read port may carry different data widths over one shared storage array. Each port has an address register with an active-high hold input. While hold is high at a clock edge, the port keeps using the address it latched last and ignores the address bus. The read data leaves the block either straight from the read latch or through an optional output register, chosen by a parameter. An asynchronous clear forces the read data to zero at once in either arrangement.

A typical use is packing narrow samples into a wide word. A producer writes bytes and a consumer reads 32-bit words. The write hold lets the producer keep overwriting one location while its address bus is busy with something else.

Top module: `mwram_stall`

## Requirements
- R1: With 8-bit writes and 32-bit reads, narrow address a sits in wide word a/4 at bits [(a%4)*8 +: 8], so the lowest narrow address lands in the least significant byte.
- R2: The read data for a read enabled at clock edge E appears after E when OUT_REG=0, and only after edge E+1 when OUT_REG=1. Until then the earlier value stays on rd_data.
- R3: A write at an edge where wr_hold is high goes to the write address latched at the last edge where wr_hold was low, and the address on the bus is ignored. Repeated held writes overwrite that location.
- R4: At an edge where wr_hold is low, the write uses the bus address and latches it.
- R5: A read at an edge where rd_hold is high uses the read address latched earlier and ignores rd_addr.
- R6: A read and a write to the same location at the same edge return the data held before that write.
- R7: Raising clr forces rd_data to zero without waiting for a clock edge, with or without the output register. The output register is cleared as well.
- R8: After clr falls, rd_data stays zero until a read is clocked out.
- R9: While rd_en is low, rd_data keeps its value.
- R10: clr also returns both latched addresses to zero.
- R11: A write cycle with wr_en low leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| clr | input | 1 | Asynchronous clear of the read output stage and the address latches |
| wr_addr | input | WA_W | Write address, in write-width words |
| wr_data | input | WR_W | Write data |
| wr_en | input | 1 | Write enable, sampled on the rising edge |
| wr_hold | input | 1 | Keeps the latched write address |
| rd_addr | input | RA_W | Read address, in read-width words |
| rd_en | input | 1 | Read enable |
| rd_hold | input | 1 | Keeps the latched read address |
| rd_data | output | RD_W | Read data |

## Verification
A latched address that fails to hold or to resample puts a byte in the wrong lane or the wrong row. That fault stays hidden until the affected word is read back, one or two edges after the read. A stale output-register stage shows up one edge late as an early or missing update, and an uncleared register shows up within a nanosecond of clr rising. Because both latencies are visible at the ports, the bench runs the same stimulus on both output configurations side by side.

// File: rtl/mwram_pkg.sv
package mwram_pkg;
    // Number of lane-select bits for a width ratio; at least one so slices stay legal.
    function automatic int lane_bits(input int ratio);
        return (ratio > 1) ? $clog2(ratio) : 1;
    endfunction
endpackage

// File: rtl/mwram_addr.sv
module mwram_addr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          hold,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_eff,
    output logic [AW-1:0] addr_q
);
    logic [AW-1:0] addr_d;

    always_comb begin
        addr_d = hold ? addr_q : addr_in;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) addr_q <= '0;
        else     addr_q <= addr_d;
    end

    // The array acts at this edge on the address the latch is about to hold.
    assign addr_eff = addr_d;
endmodule

// File: rtl/mwram_array.sv
module mwram_array #(
    parameter int WR_W     = 8,
    parameter int RD_W     = 32,
    parameter int WR_DEPTH = 64
) (
    input  logic                            clk,
    input  logic                            we,
    input  logic [$clog2(WR_DEPTH)-1:0]     waddr,
    input  logic [WR_W-1:0]                 wdata,
    input  logic [$clog2(WR_DEPTH*WR_W/RD_W)-1:0] raddr,
    output logic [RD_W-1:0]                 rword
);
    localparam int WIDE_W   = (WR_W > RD_W) ? WR_W : RD_W;
    localparam int NARROW_W = (WR_W > RD_W) ? RD_W : WR_W;
    localparam int RATIO    = WIDE_W / NARROW_W;
    localparam int LB       = mwram_pkg::lane_bits(RATIO);
    localparam int ROWS     = WR_DEPTH * WR_W / WIDE_W;
    localparam int WA_W     = $clog2(WR_DEPTH);
    localparam int RA_W     = $clog2(WR_DEPTH * WR_W / RD_W);

    generate
        if (WR_W == RD_W) begin : g_equal
            logic [WIDE_W-1:0] mem [ROWS];
            always_ff @(posedge clk) begin
                if (we) mem[waddr] <= wdata;
            end
            assign rword = mem[raddr];
        end else if (WR_W < RD_W) begin : g_narrow_wr
            logic [WIDE_W-1:0] mem [ROWS];
            always_ff @(posedge clk) begin
                if (we) mem[waddr[WA_W-1:LB]][waddr[LB-1:0]*WR_W +: WR_W] <= wdata;
            end
            assign rword = mem[raddr];
        end else begin : g_narrow_rd
            logic [WIDE_W-1:0] mem [ROWS];
            always_ff @(posedge clk) begin
                if (we) mem[waddr] <= wdata;
            end
            assign rword = mem[raddr[RA_W-1:LB]][raddr[LB-1:0]*RD_W +: RD_W];
        end
    endgenerate
endmodule

// File: rtl/mwram_stall.sv
module mwram_stall #(
    parameter int WR_W     = 8,
    parameter int RD_W     = 32,
    parameter int WR_DEPTH = 64,
    parameter bit OUT_REG  = 1'b1,
    localparam int WA_W    = $clog2(WR_DEPTH),
    localparam int RA_W    = $clog2(WR_DEPTH * WR_W / RD_W)
) (
    input  logic            clk,
    input  logic            clr,
    input  logic [WA_W-1:0] wr_addr,
    input  logic [WR_W-1:0] wr_data,
    input  logic            wr_en,
    input  logic            wr_hold,
    input  logic [RA_W-1:0] rd_addr,
    input  logic            rd_en,
    input  logic            rd_hold,
    output logic [RD_W-1:0] rd_data
);
    typedef struct packed {
        logic [RD_W-1:0] lat;
        logic [RD_W-1:0] oreg;
    } out_t;

    logic [WA_W-1:0] wa_eff, wa_q;
    logic [RA_W-1:0] ra_eff, ra_q;
    logic [RD_W-1:0] rword;
    out_t            out_d, out_q;

    mwram_addr #(.AW(WA_W)) u_wa (
        .clk(clk), .clr(clr), .hold(wr_hold), .addr_in(wr_addr),
        .addr_eff(wa_eff), .addr_q(wa_q)
    );

    mwram_addr #(.AW(RA_W)) u_ra (
        .clk(clk), .clr(clr), .hold(rd_hold), .addr_in(rd_addr),
        .addr_eff(ra_eff), .addr_q(ra_q)
    );

    mwram_array #(.WR_W(WR_W), .RD_W(RD_W), .WR_DEPTH(WR_DEPTH)) u_mem (
        .clk(clk), .we(wr_en), .waddr(wa_eff), .wdata(wr_data),
        .raddr(ra_eff), .rword(rword)
    );

    always_comb begin
        out_d      = out_q;
        if (rd_en) out_d.lat = rword;
        out_d.oreg = out_q.lat;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) out_q <= '0;
        else     out_q <= out_d;
    end

    generate
        if (OUT_REG) begin : g_oreg
            assign rd_data = out_q.oreg;
        end else begin : g_latch
            assign rd_data = out_q.lat;
        end
    endgenerate
endmodule

// File: rtl/mwram_chk.sv
module mwram_chk #(
    parameter int WA_W = 6,
    parameter int RA_W = 4,
    parameter int RD_W = 32
) (
    input logic            clk,
    input logic            clr,
    input logic            wr_hold,
    input logic [WA_W-1:0] wr_addr,
    input logic            rd_hold,
    input logic            rd_en,
    input logic [RD_W-1:0] rd_data,
    input logic [WA_W-1:0] wa_q,
    input logic [RA_W-1:0] ra_q
);
    // R7: output is zero whenever clear is high (sampled mid-cycle)
    a_r7_clear_zero: assert property (@(negedge clk) clr |-> rd_data == '0);

    // R10: address latches are zero while clear is high
    a_r10_addr_clear: assert property (@(posedge clk) clr |-> (wa_q == '0 && ra_q == '0));

    // R3: held write address does not move
    a_r3_wr_hold: assert property (@(posedge clk) disable iff (clr) wr_hold |=> $stable(wa_q));

    // R4: released write hold latches the bus address
    a_r4_wr_resample: assert property (@(posedge clk) disable iff (clr)
        !wr_hold |=> wa_q == $past(wr_addr));

    // R5: held read address does not move
    a_r5_rd_hold: assert property (@(posedge clk) disable iff (clr) rd_hold |=> $stable(ra_q));

    // R9: two quiet read cycles leave the output unchanged
    a_r9_quiet_out: assert property (@(posedge clk) disable iff (clr)
        (!rd_en && !$past(rd_en)) |=> $stable(rd_data));
endmodule

bind mwram_stall mwram_chk #(.WA_W(WA_W), .RA_W(RA_W), .RD_W(RD_W)) u_chk (
    .clk(clk), .clr(clr), .wr_hold(wr_hold), .wr_addr(wr_addr),
    .rd_hold(rd_hold), .rd_en(rd_en), .rd_data(rd_data),
    .wa_q(wa_q), .ra_q(ra_q)
);

// File: tb/sim_mwram_stall.sv
`timescale 1ns/1ps
module sim_mwram_stall;
    logic        clk = 1'b0;
    logic        clr = 1'b1;
    logic [5:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_en = 1'b0, wr_hold = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic        rd_en = 1'b0, rd_hold = 1'b0;
    logic [31:0] q_reg, q_lat;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    mwram_stall #(.OUT_REG(1'b1)) u0 (
        .clk(clk), .clr(clr), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
        .wr_hold(wr_hold), .rd_addr(rd_addr), .rd_en(rd_en), .rd_hold(rd_hold),
        .rd_data(q_reg)
    );

    mwram_stall #(.OUT_REG(1'b0)) u1 (
        .clk(clk), .clr(clr), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
        .wr_hold(wr_hold), .rd_addr(rd_addr), .rd_en(rd_en), .rd_hold(rd_hold),
        .rd_data(q_lat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d, input logic en, input logic hold);
        wr_addr = a; wr_data = d; wr_en = en; wr_hold = hold;
        tick();
        wr_en = 1'b0; wr_hold = 1'b0;
    endtask

    task automatic rd_both(input logic [3:0] a, input logic [31:0] exp, input string req);
        rd_addr = a; rd_en = 1'b1; rd_hold = 1'b0;
        tick();
        rd_en = 1'b0;
        check(req, q_lat, exp);
        tick();
        check(req, q_reg, exp);
    endtask

    task automatic t_reset();
        check("R7", q_reg, 32'h0);
        check("R7", q_lat, 32'h0);
        clr = 1'b0;
        // R10: held write right after clear goes to address 0
        wr(6'd5, 8'hAA, 1'b1, 1'b1);
        rd_addr = 4'd0; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        check("R10", {24'h0, q_lat[7:0]}, 32'h0000_00AA);
        tick();
    endtask

    task automatic t_lanes();
        logic [31:0] prev;
        wr(6'd4, 8'h11, 1'b1, 1'b0);
        wr(6'd5, 8'h22, 1'b1, 1'b0);
        wr(6'd6, 8'h33, 1'b1, 1'b0);
        wr(6'd7, 8'h44, 1'b1, 1'b0);
        prev = q_reg;
        rd_addr = 4'd1; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        check("R1", q_lat, 32'h4433_2211);
        check("R2", q_reg, prev);
        tick();
        check("R2", q_reg, 32'h4433_2211);
    endtask

    task automatic t_wr_hold();
        for (int i = 8; i < 12; i++) wr(6'(i), 8'h00, 1'b1, 1'b0);
        wr(6'd8,  8'h55, 1'b1, 1'b0);
        wr(6'd9,  8'h66, 1'b1, 1'b1);
        wr(6'd10, 8'h77, 1'b1, 1'b1);
        wr(6'd11, 8'h88, 1'b1, 1'b0);
        rd_both(4'd2, 32'h8800_0077, "R3");
        check("R4", {24'h0, q_reg[31:24]}, 32'h0000_0088);
    endtask

    task automatic t_wr_en_low();
        wr(6'd12, 8'h01, 1'b1, 1'b0);
        wr(6'd13, 8'h02, 1'b1, 1'b0);
        wr(6'd14, 8'h03, 1'b1, 1'b0);
        wr(6'd15, 8'h04, 1'b1, 1'b0);
        wr(6'd12, 8'hFF, 1'b0, 1'b0);
        rd_both(4'd3, 32'h0403_0201, "R11");
    endtask

    task automatic t_rd_hold();
        rd_addr = 4'd3; rd_en = 1'b1; rd_hold = 1'b0;
        tick();
        rd_addr = 4'd1;
        tick();
        rd_addr = 4'd3; rd_hold = 1'b1;
        tick();
        rd_en = 1'b0; rd_hold = 1'b0;
        check("R5", q_lat, 32'h4433_2211);
        tick();
        check("R5", q_reg, 32'h4433_2211);
    endtask

    task automatic t_collision();
        wr_addr = 6'd12; wr_data = 8'hAB; wr_en = 1'b1;
        rd_addr = 4'd3;  rd_en = 1'b1;
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
        check("R6", q_lat, 32'h0403_0201);
        tick();
        check("R6", q_reg, 32'h0403_0201);
        rd_both(4'd3, 32'h0403_02AB, "R6");
    endtask

    task automatic t_quiet();
        rd_en = 1'b0;
        rd_addr = 4'd1;
        tick(); tick(); tick();
        check("R9", q_lat, 32'h0403_02AB);
        check("R9", q_reg, 32'h0403_02AB);
    endtask

    task automatic t_clear();
        #5 clr = 1'b1;
        #1;
        check("R7", q_lat, 32'h0);
        check("R7", q_reg, 32'h0);
        @(negedge clk);
        clr = 1'b0;
        tick(); tick();
        check("R8", q_lat, 32'h0);
        check("R8", q_reg, 32'h0);
        rd_both(4'd3, 32'h0403_02AB, "R8");
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_lanes();
        t_wr_hold();
        t_wr_en_low();
        t_rd_hold();
        t_collision();
        t_quiet();
        t_clear();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule